// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between an 8-bit CPU's 16-bit address bus and a banked cartridge that holds up to 128 ROM banks of 16 KB and up to 32 KB of external RAM. The CPU cannot write to ROM, so writes that land in the lower 32 KB of the address space are taken as control writes. They load four small registers: a RAM enable flag, a 5-bit lower bank number, a 2-bit upper bank number and a mode flag.

CPU accesses to 0x0000–0x7FFF are translated into a physical ROM byte address. The lower 16 KB is a fixed window, which mode 1 can remap. The upper 16 KB is a switchable window. Accesses to 0xA000–0xBFFF go to external RAM through a translated RAM address and a RAM enable, or else return an open-bus value while RAM is disabled.

ROM bank count and RAM size are static configuration inputs, and each changes how the registers are combined. The ROM arrays, the RAM arrays and the external bus timing lie outside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the RAM is disabled, the lower bank register holds 1, the upper bank register holds 0 and mode is 0. A read of 0x4000 therefore gives ROM address 0x4000, and a RAM-window read is overridden.
- R2: In mode 0 a CPU address in 0x0000–0x3FFF is passed to `rom_addr` unchanged.
- R3: A write to 0x2000–0x3FFF with data 0x00 loads the lower bank register with 1. Any other data byte is ANDed with a ROM-size mask and kept to 5 bits. The `cfg_rom_banks` codes 0..7 mean 2, 4, 8, 16, 32, 64, 128 and 128 banks. The mask is 0x01, 0x03, 0x07 and 0x0F for codes 0 to 3, and 0x1F for codes 4 and up.
- R4: A CPU address in 0x4000–0x7FFF gives `rom_addr` = 0x4000 × high_bank + (address − 0x4000). Here high_bank is the masked lower bank number with the upper-bank bits of R6 placed above it.
- R5: A write to 0x4000–0x5FFF loads the upper bank register from data bits 1:0. A write to 0x6000–0x7FFF loads the mode flag from data bit 0.
- R6: The upper bank register supplies bank bit 5 from its bit 0 for code 5 (64 banks), and bank bits 6:5 for codes 6 and 7. For codes 0–4 it has no effect on `rom_addr`.
- R7: In mode 1 a CPU address in 0x0000–0x3FFF gives `rom_addr` = 0x4000 × zero_bank + address. Here zero_bank is the R6 upper-bank bits placed at bit 5 and above, with its low 5 bits zero.
- R8: A write to 0x0000–0x1FFF enables RAM when data bits 3:0 equal 0xA, whatever bits 7:4 are. Any other data disables RAM.
- R9: While RAM is disabled, a read of 0xA000–0xBFFF asserts `ovr_valid` with `ovr_data` = 0xFF, and `ram_en` and `ram_we` stay low for reads and writes. While RAM is enabled, such an access asserts `ram_en` (and `ram_we` for a write) and `ovr_valid` stays low.
- R10: `ram_addr` depends on `cfg_ram_size`. Code 0 (2 KB) gives (address − 0xA000) mod 0x800. Code 1 (8 KB) gives address − 0xA000. Codes 2 and 3 (32 KB) give 0x2000 × upper register + (address − 0xA000) in mode 1, and address − 0xA000 in mode 0.
- R11: A register write takes effect on the rising clock edge at which `cpu_wr` is sampled. Address translation is combinational from the current register state and the current CPU address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cfg_rom_banks | input | 3 | ROM bank count code (see R3) |
| cfg_ram_size | input | 2 | RAM size code (see R10) |
| rom_addr | output | 21 | Physical ROM byte address (zero outside 0x0000–0x7FFF) |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ovr_valid | output | 1 | Read data must be replaced by `ovr_data` |
| ovr_data | output | 8 | Open-bus value for a disabled RAM |

## Verification
Translation results (`rom_addr`, `ram_addr`, `ram_en`, `ram_we`, `ovr_valid`) depend on the address combinationally, so they are due in the same cycle as the address. A register write shows up in them only after the one rising edge that samples `cpu_wr`. The bench drives every input on the falling edge. It samples outputs 1 ns after a change, so it always reads them between edges. Each write runs for exactly one rising edge before its result is read. The R11 scenario samples the new bank immediately after the capturing edge. It then changes the address with no further edge to show that translation follows the address at once.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

   localparam int CPU_ADDR_W = 16;

   // Region selected by CPU address bits 15:13
   typedef enum logic [2:0] {
      RG_RAMCTL = 3'd0,
      RG_BANKLO = 3'd1,
      RG_BANKHI = 3'd2,
      RG_MODE   = 3'd3,
      RG_VIDEO  = 3'd4,
      RG_XRAM   = 3'd5,
      RG_WRAM   = 3'd6,
      RG_TOP    = 3'd7
   } cbm_region_e;

   function automatic cbm_region_e region_of(input logic [CPU_ADDR_W-1:0] a);
      return cbm_region_e'(a[CPU_ADDR_W-1 -: 3]);
   endfunction

endpackage

// File: rtl/cbm_regs.sv
module cbm_regs #(
   parameter int DATA_W    = 8,
   parameter int BANK_LO_W = 5,
   parameter int BANK_HI_W = 2,
   parameter int SEL_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  cbm_pkg::cbm_region_e region,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [SEL_W-1:0]     rom_sel,
   output logic                 ram_on,
   output logic [BANK_LO_W-1:0] bank_lo,
   output logic [BANK_HI_W-1:0] bank_hi,
   output logic                 mode
);
   import cbm_pkg::*;

   if (DATA_W < BANK_LO_W) begin : g_bad_data_w
      $error("cbm_regs: DATA_W must cover BANK_LO_W");
   end
   if (DATA_W < BANK_HI_W) begin : g_bad_hi_w
      $error("cbm_regs: DATA_W must cover BANK_HI_W");
   end

   logic [BANK_LO_W-1:0] size_mask;
   logic [BANK_LO_W-1:0] lo_next;

   always_comb begin
      for (int i = 0; i < BANK_LO_W; i++) begin
         size_mask[i] = (int'(rom_sel) >= i);
      end
      if (wdata == '0) begin
         lo_next = BANK_LO_W'(1);
      end else begin
         lo_next = wdata[BANK_LO_W-1:0] & size_mask;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_on  <= 1'b0;
         bank_lo <= BANK_LO_W'(1);
         bank_hi <= '0;
         mode    <= 1'b0;
      end else if (wr_en) begin
         unique case (region)
            RG_RAMCTL: ram_on  <= (wdata[3:0] == 4'hA);
            RG_BANKLO: bank_lo <= lo_next;
            RG_BANKHI: bank_hi <= wdata[BANK_HI_W-1:0];
            RG_MODE:   mode    <= wdata[0];
            default:   ;
         endcase
      end
   end

   // R3: a zero data byte always lands as bank 1
   assert_zero_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && region == RG_BANKLO && wdata == '0) |=> (bank_lo == BANK_LO_W'(1)));

   // R5: mode flag follows data bit 0 of a mode write
   assert_mode_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && region == RG_MODE) |=> (mode == $past(wdata[0])));

   // R8: RAM enable follows the 0xA nibble
   assert_ram_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && region == RG_RAMCTL) |=> (ram_on == ($past(wdata[3:0]) == 4'hA)));

   // R11: no register moves without a write strobe
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(bank_lo) && $stable(bank_hi) && $stable(mode) && $stable(ram_on)));

endmodule

// File: rtl/cbm_rom_xlate.sv
module cbm_rom_xlate #(
   parameter int BANK_LO_W      = 5,
   parameter int BANK_HI_W      = 2,
   parameter int WIN_W          = 14,
   parameter int SEL_W          = 3,
   parameter bit MODE1_REMAP    = 1'b1,
   localparam int BANK_W        = BANK_LO_W + BANK_HI_W,
   localparam int ROM_ADDR_W    = BANK_W + WIN_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [cbm_pkg::CPU_ADDR_W-1:0] cpu_addr,
   input  logic                          mode,
   input  logic [BANK_LO_W-1:0]          bank_lo,
   input  logic [BANK_HI_W-1:0]          bank_hi,
   input  logic [SEL_W-1:0]              rom_sel,
   output logic [ROM_ADDR_W-1:0]         rom_addr
);
   import cbm_pkg::*;

   if (WIN_W + 2 != CPU_ADDR_W) begin : g_bad_win
      $error("cbm_rom_xlate: two ROM windows must fill the lower half of the CPU space");
   end

   logic [BANK_LO_W-1:0] size_mask;
   logic [BANK_HI_W-1:0] upper;
   logic [BANK_W-1:0]    high_bank;
   logic [BANK_W-1:0]    zero_bank;
   logic [BANK_W-1:0]    fixed_bank;
   logic [WIN_W-1:0]     offset;
   logic                 in_rom;
   logic                 in_high;

   always_comb begin
      for (int i = 0; i < BANK_LO_W; i++) begin
         size_mask[i] = (int'(rom_sel) >= i);
      end
      for (int j = 0; j < BANK_HI_W; j++) begin
         upper[j] = bank_hi[j] & (int'(rom_sel) >= BANK_LO_W + j);
      end
      high_bank = {upper, bank_lo & size_mask};
      zero_bank = {upper, {BANK_LO_W{1'b0}}};
   end

   if (MODE1_REMAP) begin : g_remap
      assign fixed_bank = mode ? zero_bank : '0;
   end else begin : g_no_remap
      assign fixed_bank = '0;
   end

   assign offset  = cpu_addr[WIN_W-1:0];
   assign in_rom  = ~cpu_addr[CPU_ADDR_W-1];
   assign in_high = cpu_addr[WIN_W];

   always_comb begin
      if (!in_rom) begin
         rom_addr = '0;
      end else if (in_high) begin
         rom_addr = {high_bank, offset};
      end else begin
         rom_addr = {fixed_bank, offset};
      end
   end

   // R2: mode 0 passes the fixed window through
   assert_fixed_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode && cpu_addr[CPU_ADDR_W-1 -: 2] == 2'b00) |->
         (rom_addr == ROM_ADDR_W'(cpu_addr)));

   // R6: small ROMs never see the upper bank bits
   assert_upper_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rom_sel) < BANK_LO_W) |-> (rom_addr[ROM_ADDR_W-1 -: BANK_HI_W] == '0));

   // R4: switchable window keeps the in-bank offset
   assert_high_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[CPU_ADDR_W-1 -: 2] == 2'b01) |-> (rom_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]));

endmodule

// File: rtl/cbm_ram_xlate.sv
module cbm_ram_xlate #(
   parameter int          BANK_HI_W   = 2,
   parameter int          RAM_OFS_W   = 13,
   parameter int          RAM_SMALL_W = 11,
   parameter int          DATA_W      = 8,
   parameter logic [7:0]  OPEN_BUS    = 8'hFF,
   localparam int         RAM_ADDR_W  = RAM_OFS_W + BANK_HI_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [cbm_pkg::CPU_ADDR_W-1:0] cpu_addr,
   input  logic                          cpu_rd,
   input  logic                          cpu_wr,
   input  logic                          ram_on,
   input  logic                          mode,
   input  logic [BANK_HI_W-1:0]          bank_hi,
   input  logic [1:0]                    ram_sel,
   output logic [RAM_ADDR_W-1:0]         ram_addr,
   output logic                          ram_en,
   output logic                          ram_we,
   output logic                          ovr_valid,
   output logic [DATA_W-1:0]             ovr_data
);
   import cbm_pkg::*;

   if (RAM_SMALL_W > RAM_OFS_W) begin : g_bad_small
      $error("cbm_ram_xlate: small RAM cannot exceed the window");
   end
   if (RAM_OFS_W + 3 != CPU_ADDR_W) begin : g_bad_ofs
      $error("cbm_ram_xlate: RAM window must be an eighth of the CPU space");
   end

   logic [RAM_OFS_W-1:0] offset;
   logic                 in_win;

   assign offset = cpu_addr[RAM_OFS_W-1:0];
   assign in_win = (region_of(cpu_addr) == RG_XRAM);

   always_comb begin
      unique case (ram_sel)
         2'd0:    ram_addr = RAM_ADDR_W'(offset[RAM_SMALL_W-1:0]);
         2'd1:    ram_addr = RAM_ADDR_W'(offset);
         default: ram_addr = mode ? {bank_hi, offset} : RAM_ADDR_W'(offset);
      endcase
   end

   assign ram_en    = in_win & ram_on & (cpu_rd | cpu_wr);
   assign ram_we    = in_win & ram_on & cpu_wr;
   assign ovr_valid = in_win & ~ram_on & cpu_rd;
   assign ovr_data  = DATA_W'(OPEN_BUS);

   // R9: a disabled RAM is never accessed
   assert_ram_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_on |-> (!ram_en && !ram_we));

   // R9: override and real access exclude each other
   assert_ovr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_valid |-> !ram_en);

   // R10: mode 0 always uses RAM bank 0
   assert_bank0_mode0_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |-> (ram_addr[RAM_ADDR_W-1 -: BANK_HI_W] == '0));

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
   parameter int         DATA_W      = 8,
   parameter int         BANK_LO_W   = 5,
   parameter int         BANK_HI_W   = 2,
   parameter int         WIN_W       = 14,
   parameter int         RAM_OFS_W   = 13,
   parameter int         RAM_SMALL_W = 11,
   parameter int         SEL_W       = 3,
   parameter bit         MODE1_REMAP = 1'b1,
   parameter logic [7:0] OPEN_BUS    = 8'hFF,
   localparam int        ROM_ADDR_W  = BANK_LO_W + BANK_HI_W + WIN_W,
   localparam int        RAM_ADDR_W  = RAM_OFS_W + BANK_HI_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           cpu_addr,
   input  logic [DATA_W-1:0]     cpu_wdata,
   input  logic                  cpu_wr,
   input  logic                  cpu_rd,
   input  logic [SEL_W-1:0]      cfg_rom_banks,
   input  logic [1:0]            cfg_ram_size,
   output logic [ROM_ADDR_W-1:0] rom_addr,
   output logic [RAM_ADDR_W-1:0] ram_addr,
   output logic                  ram_en,
   output logic                  ram_we,
   output logic                  ovr_valid,
   output logic [DATA_W-1:0]     ovr_data
);
   import cbm_pkg::*;

   if ((1 << SEL_W) < BANK_LO_W + BANK_HI_W) begin : g_bad_sel
      $error("cart_bank_mapper: SEL_W too narrow for the bank width");
   end

   logic                 ram_on;
   logic [BANK_LO_W-1:0] bank_lo;
   logic [BANK_HI_W-1:0] bank_hi;
   logic                 mode;
   logic                 ctl_wr;

   assign ctl_wr = cpu_wr & ~cpu_addr[15];

   cbm_regs #(
      .DATA_W(DATA_W), .BANK_LO_W(BANK_LO_W), .BANK_HI_W(BANK_HI_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .region(region_of(cpu_addr)),
      .wdata(cpu_wdata), .rom_sel(cfg_rom_banks),
      .ram_on(ram_on), .bank_lo(bank_lo), .bank_hi(bank_hi), .mode(mode)
   );

   cbm_rom_xlate #(
      .BANK_LO_W(BANK_LO_W), .BANK_HI_W(BANK_HI_W), .WIN_W(WIN_W),
      .SEL_W(SEL_W), .MODE1_REMAP(MODE1_REMAP)
   ) u_rom (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mode(mode),
      .bank_lo(bank_lo), .bank_hi(bank_hi), .rom_sel(cfg_rom_banks),
      .rom_addr(rom_addr)
   );

   cbm_ram_xlate #(
      .BANK_HI_W(BANK_HI_W), .RAM_OFS_W(RAM_OFS_W), .RAM_SMALL_W(RAM_SMALL_W),
      .DATA_W(DATA_W), .OPEN_BUS(OPEN_BUS)
   ) u_ram (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .ram_on(ram_on), .mode(mode), .bank_hi(bank_hi),
      .ram_sel(cfg_ram_size), .ram_addr(ram_addr), .ram_en(ram_en),
      .ram_we(ram_we), .ovr_valid(ovr_valid), .ovr_data(ovr_data)
   );

endmodule

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cpu_addr;
   logic [7:0]  cpu_wdata;
   logic        cpu_wr;
   logic        cpu_rd;
   logic [2:0]  cfg_rom_banks;
   logic [1:0]  cfg_ram_size;
   logic [20:0] rom_addr;
   logic [14:0] ram_addr;
   logic        ram_en;
   logic        ram_we;
   logic        ovr_valid;
   logic [7:0]  ovr_data;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   cart_bank_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cfg_rom_banks(cfg_rom_banks),
      .cfg_ram_size(cfg_ram_size), .rom_addr(rom_addr), .ram_addr(ram_addr),
      .ram_en(ram_en), .ram_we(ram_we), .ovr_valid(ovr_valid), .ovr_data(ovr_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one write: driven at a falling edge, captured by the next rising edge
   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rom_at(input string tag, input logic [15:0] a, input logic [20:0] exp);
      cpu_addr = a; cpu_rd = 1'b1;
      #1;
      chk(tag, 32'(rom_addr), 32'(exp));
      cpu_rd = 1'b0;
   endtask

   task automatic t_reset();
      cfg_rom_banks = 3'd6; cfg_ram_size = 2'd2;
      rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0; cpu_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rom_at("R1 bank1 after reset", 16'h4000, 21'h04000);
      rom_at("R2 fixed pass", 16'h0123, 21'h00123);
      cpu_addr = 16'hA000; cpu_rd = 1'b1; #1;
      chk("R1 ram off ovr_valid", 32'(ovr_valid), 1);
      chk("R9 ovr_data", 32'(ovr_data), 32'hFF);
      chk("R9 ram_en low", 32'(ram_en), 0);
      cpu_rd = 1'b0;
   endtask

   task automatic t_lowbank();
      cfg_rom_banks = 3'd4;
      cpu_write(16'h2000, 8'h00);
      rom_at("R3 zero gives bank1", 16'h4005, 21'h04005);
      cpu_write(16'h3FFF, 8'h13);
      rom_at("R4 bank 0x13", 16'h4005, 21'h4C005);
      cpu_write(16'h2000, 8'hFF);
      rom_at("R3 5-bit limit", 16'h4005, 21'h7C005);
      cfg_rom_banks = 3'd2;
      cpu_write(16'h2000, 8'h1D);
      rom_at("R3 8-bank mask", 16'h4005, 21'h14005);
      cfg_rom_banks = 3'd0;
      cpu_write(16'h2000, 8'h02);
      rom_at("R3 2-bank mask to 0", 16'h4005, 21'h00005);
   endtask

   task automatic t_upper();
      cfg_rom_banks = 3'd6;
      cpu_write(16'h2000, 8'h01);
      cpu_write(16'h4000, 8'hFF);
      rom_at("R6 128 banks", 16'h4010, 21'h184010);
      cfg_rom_banks = 3'd5;
      rom_at("R6 64 banks", 16'h4010, 21'h084010);
      cfg_rom_banks = 3'd4;
      rom_at("R6 32 banks ignores upper", 16'h4010, 21'h004010);
      rom_at("R5 mode 0 fixed window", 16'h0010, 21'h000010);
   endtask

   task automatic t_mode1();
      cfg_rom_banks = 3'd6;
      cpu_write(16'h5FFF, 8'h02);
      cpu_write(16'h6000, 8'h01);
      rom_at("R7 128 banks zero_bank", 16'h0100, 21'h100100);
      cfg_rom_banks = 3'd5;
      rom_at("R7 64 banks bit5 clear", 16'h0100, 21'h000100);
      cpu_write(16'h4000, 8'h01);
      rom_at("R7 64 banks bit5 set", 16'h0100, 21'h080100);
      cfg_rom_banks = 3'd4;
      rom_at("R7 32 banks ignored", 16'h0100, 21'h000100);
      cfg_rom_banks = 3'd6;
      cpu_write(16'h7000, 8'hFE);
      rom_at("R5 mode cleared", 16'h0100, 21'h000100);
   endtask

   task automatic t_ram();
      cfg_ram_size = 2'd1;
      cpu_write(16'h0000, 8'h5A);
      cpu_addr = 16'hA123; cpu_rd = 1'b1; #1;
      chk("R8 enabled ram_en", 32'(ram_en), 1);
      chk("R9 no ovr when on", 32'(ovr_valid), 0);
      chk("R10 8KB addr", 32'(ram_addr), 32'h123);
      cpu_addr = 16'hBFFF; #1;
      chk("R10 8KB top", 32'(ram_addr), 32'h1FFF);
      cfg_ram_size = 2'd0; #1;
      chk("R10 2KB wrap", 32'(ram_addr), 32'h7FF);
      cpu_rd = 1'b0;
      cfg_ram_size = 2'd2;
      cpu_write(16'h4000, 8'h02);
      cpu_write(16'h6000, 8'h01);
      cpu_addr = 16'hA010; cpu_rd = 1'b1; #1;
      chk("R10 32KB mode1", 32'(ram_addr), 32'h4010);
      cpu_rd = 1'b0;
      cpu_write(16'h6000, 8'h00);
      cpu_addr = 16'hA010; cpu_rd = 1'b1; #1;
      chk("R10 32KB mode0", 32'(ram_addr), 32'h0010);
      cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_addr = 16'hA005; #1;
      chk("R9 write when on ram_we", 32'(ram_we), 1);
      cpu_wr = 1'b0;
      cpu_write(16'h1000, 8'h0B);
      cpu_addr = 16'hA005; cpu_wr = 1'b1; #1;
      chk("R8 disabled ram_we", 32'(ram_we), 0);
      chk("R9 disabled write ram_en", 32'(ram_en), 0);
      cpu_wr = 1'b0; cpu_rd = 1'b1; #1;
      chk("R9 disabled read ovr", 32'(ovr_valid), 1);
      cpu_rd = 1'b0;
   endtask

   task automatic t_timing();
      cfg_rom_banks = 3'd4;
      @(negedge clk);
      cpu_addr = 16'h2000; cpu_wdata = 8'h07; cpu_wr = 1'b1;
      @(posedge clk);
      #1;
      cpu_wr = 1'b0; cpu_addr = 16'h4000; #1;
      chk("R11 visible after capture edge", 32'(rom_addr), 32'h1C000);
      cpu_addr = 16'h7FFF; #1;
      chk("R11 combinational address", 32'(rom_addr), 32'h1FFFF);
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_lowbank();
      t_upper();
      t_mode1();
      t_ram();
      t_timing();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule